// File: doc/BRIEF.md
# Micro-op cracking and three-wide dispatch buffer

This block sits between instruction decode and the out-of-order back end. Each cycle it can take a group of up to three decoded instructions. Each instruction is marked as either register-to-register or register-with-memory-operand. A register-to-register instruction becomes one ALU micro-op. An instruction with a memory operand is split into two micro-ops: a memory micro-op (load/store and address work) followed by a register ALU micro-op. A full group therefore turns into anywhere from three to six micro-ops.

The micro-ops are written into a circular buffer in program order. They are offered to the back end three at a time. The back end grants or refuses the whole three-wide bundle with a single ready line. The block holds off the decode stage whenever the buffer might not fit a worst-case group of six. A flush input discards everything held, plus any group offered in the same cycle.

Top module: `uop_crack_dispatch`

## Requirements
- R1: A group is accepted on a clock edge where inReady is 1, flush is 0 and at least one inValid bit is set. Lanes are taken in order 0, 1, 2, and lanes with inValid 0 produce nothing.
- R2: A lane with inMemForm 0 produces exactly one micro-op with outIsMem 0, carrying the lane's opcode, destination and source fields unchanged.
- R3: A lane with inMemForm 1 produces two consecutive micro-ops with the same fields. The first has outIsMem 1 and the second has outIsMem 0.
- R4: Micro-ops leave in program order. Output lane 0 is always the oldest, and outValid is a thermometer code: 000, 001, 011 or 111.
- R5: outValid shows min(occupancy, 3) entries. When backReady is 1, every shown entry leaves on that edge, so at most three leave per cycle. Micro-ops of an accepted group are visible on the outputs from the cycle after acceptance.
- R6: inReady is 1 exactly when at least 6 of the DEPTH (default 8) entries are free. A group offered while inReady is 0 is ignored.
- R7: While backReady is 0, no entry leaves, no entry is lost, and the shown micro-ops stay unchanged unless a new group is accepted.
- R8: When flush is 1 on an edge, the buffer is empty on the next cycle (outValid 000, inReady 1), and a group offered on that edge is discarded.
- R9: After reset, outValid is 000 and inReady is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all held micro-ops and the offered group |
| inValid | input | 3 | Per-lane valid of the offered group |
| inMemForm | input | 3 | Per-lane form: 1 = memory operand, 0 = register only |
| inOpcode | input | 3x6 | Per-lane opcode |
| inDst | input | 3x5 | Per-lane destination register |
| inSrc | input | 3x5 | Per-lane source register |
| inReady | output | 1 | Buffer can take a worst-case group |
| backReady | input | 1 | Back end takes the whole shown bundle |
| outValid | output | 3 | Thermometer of shown micro-ops |
| outIsMem | output | 3 | Per-lane micro-op kind: 1 = memory, 0 = ALU |
| outOpcode | output | 3x6 | Per-lane opcode |
| outDst | output | 3x5 | Per-lane destination register |
| outSrc | output | 3x5 | Per-lane source register |

## Verification
The buffer is written and the pointers move on the edge where a group is accepted, and the outputs are read combinationally from the buffer head. An accepted group therefore shows up one cycle later. inReady and outValid reflect occupancy as of the most recent edge, and a flush empties the outputs one cycle later. The bench keeps a queue model that it updates at the same edges. It compares inReady, outValid and each shown micro-op at the falling edge, half a period before the next update, and it drives new inputs 1 ns after the rising edge.

// File: rtl/crack_pkg.sv
package crack_pkg;
  localparam int LANES    = 3;
  localparam int OP_W     = 6;
  localparam int REG_W    = 5;
  localparam int MAX_UOPS = 2 * LANES;
  localparam int SLOT_W   = $clog2(MAX_UOPS + 1);
  localparam int DISP_W   = $clog2(LANES + 1);

  typedef struct packed {
    logic             isMem;
    logic [OP_W-1:0]  opcode;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src;
  } uop_t;

  typedef struct packed {
    logic              push;
    logic [SLOT_W-1:0] pushNum;
  } strobe_t;
endpackage

// File: rtl/crack_expand.sv
module crack_expand
  import crack_pkg::*;
(
  input  logic [LANES-1:0]            inValid,
  input  logic [LANES-1:0]            inMemForm,
  input  logic [LANES-1:0][OP_W-1:0]  inOpcode,
  input  logic [LANES-1:0][REG_W-1:0] inDst,
  input  logic [LANES-1:0][REG_W-1:0] inSrc,
  output uop_t [MAX_UOPS-1:0]         slots,
  output logic [SLOT_W-1:0]           total
);
  logic [SLOT_W-1:0] pos;
  uop_t              cur;

  always_comb begin
    slots = '0;
    pos   = '0;
    cur   = '0;
    for (int i = 0; i < LANES; i++) begin
      cur.isMem  = 1'b0;
      cur.opcode = inOpcode[i];
      cur.dst    = inDst[i];
      cur.src    = inSrc[i];
      if (inValid[i]) begin
        if (inMemForm[i]) begin
          slots[pos]       = cur;
          slots[pos].isMem = 1'b1;
          slots[SLOT_W'(pos + SLOT_W'(1))] = cur;
          pos = SLOT_W'(pos + SLOT_W'(2));
        end else begin
          slots[pos] = cur;
          pos = SLOT_W'(pos + SLOT_W'(1));
        end
      end
    end
    total = pos;
  end
endmodule

// File: rtl/crack_datapath.sv
module crack_datapath
  import crack_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  strobe_t                     strobe,
  input  logic [PTR_W-1:0]            wrPtr,
  input  logic [PTR_W-1:0]            rdPtr,
  input  logic [LANES-1:0]            inValid,
  input  logic [LANES-1:0]            inMemForm,
  input  logic [LANES-1:0][OP_W-1:0]  inOpcode,
  input  logic [LANES-1:0][REG_W-1:0] inDst,
  input  logic [LANES-1:0][REG_W-1:0] inSrc,
  output logic [SLOT_W-1:0]           genCount,
  output uop_t [LANES-1:0]            outUop
);
  uop_t [MAX_UOPS-1:0] slots;
  uop_t                store [DEPTH];

  crack_expand u_expand (
    .inValid  (inValid),
    .inMemForm(inMemForm),
    .inOpcode (inOpcode),
    .inDst    (inDst),
    .inSrc    (inSrc),
    .slots    (slots),
    .total    (genCount)
  );

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      for (int k = 0; k < MAX_UOPS; k++) begin
        if (SLOT_W'(k) < strobe.pushNum) begin
          store[PTR_W'(wrPtr + PTR_W'(k))] <= slots[k];
        end
      end
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_read
    assign outUop[j] = store[PTR_W'(rdPtr + PTR_W'(j))];
  end
endmodule

// File: rtl/crack_ctrl.sv
module crack_ctrl
  import crack_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              anyValid,
  input  logic [SLOT_W-1:0] genCount,
  input  logic              backReady,
  output strobe_t           strobe,
  output logic [PTR_W-1:0]  wrPtr,
  output logic [PTR_W-1:0]  rdPtr,
  output logic              inReady,
  output logic [LANES-1:0]  outValid,
  output logic [CNT_W-1:0]  occupancy
);
  logic [CNT_W-1:0]  count;
  logic [DISP_W-1:0] visible;
  logic [CNT_W-1:0]  pushAmt;
  logic [CNT_W-1:0]  popAmt;
  logic              doPop;

  always_comb begin
    if (count >= CNT_W'(LANES)) visible = DISP_W'(LANES);
    else                        visible = DISP_W'(count);
  end

  assign inReady        = (count <= CNT_W'(DEPTH - MAX_UOPS));
  assign strobe.push    = inReady & anyValid & ~flush;
  assign strobe.pushNum = genCount;
  assign doPop          = backReady & ~flush;
  assign pushAmt        = strobe.push ? CNT_W'(genCount) : '0;
  assign popAmt         = doPop ? CNT_W'(visible) : '0;
  assign occupancy      = count;

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      count <= '0;
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      count <= CNT_W'(count + pushAmt - popAmt);
      wrPtr <= PTR_W'(wrPtr + PTR_W'(pushAmt));
      rdPtr <= PTR_W'(rdPtr + PTR_W'(popAmt));
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_valid
    assign outValid[j] = (DISP_W'(j) < visible);
  end
endmodule

// File: rtl/uop_crack_dispatch.sv
module uop_crack_dispatch
  import crack_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        flush,
  input  logic [LANES-1:0]            inValid,
  input  logic [LANES-1:0]            inMemForm,
  input  logic [LANES-1:0][OP_W-1:0]  inOpcode,
  input  logic [LANES-1:0][REG_W-1:0] inDst,
  input  logic [LANES-1:0][REG_W-1:0] inSrc,
  output logic                        inReady,
  input  logic                        backReady,
  output logic [LANES-1:0]            outValid,
  output logic [LANES-1:0]            outIsMem,
  output logic [LANES-1:0][OP_W-1:0]  outOpcode,
  output logic [LANES-1:0][REG_W-1:0] outDst,
  output logic [LANES-1:0][REG_W-1:0] outSrc
);
  strobe_t           strobe;
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [SLOT_W-1:0] genCount;
  logic [CNT_W-1:0]  occupancy;
  uop_t [LANES-1:0]  outUop;

  crack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .anyValid (|inValid),
    .genCount (genCount),
    .backReady(backReady),
    .strobe   (strobe),
    .wrPtr    (wrPtr),
    .rdPtr    (rdPtr),
    .inReady  (inReady),
    .outValid (outValid),
    .occupancy(occupancy)
  );

  crack_datapath #(.DEPTH(DEPTH)) u_data (
    .clk      (clk),
    .strobe   (strobe),
    .wrPtr    (wrPtr),
    .rdPtr    (rdPtr),
    .inValid  (inValid),
    .inMemForm(inMemForm),
    .inOpcode (inOpcode),
    .inDst    (inDst),
    .inSrc    (inSrc),
    .genCount (genCount),
    .outUop   (outUop)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_out
    assign outIsMem[j]  = outUop[j].isMem;
    assign outOpcode[j] = outUop[j].opcode;
    assign outDst[j]    = outUop[j].dst;
    assign outSrc[j]    = outUop[j].src;
  end
endmodule

// File: rtl/crack_checker.sv
module crack_checker
  import crack_pkg::*;
#(
  parameter  int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        flush,
  input logic [LANES-1:0]            inValid,
  input logic                        inReady,
  input logic                        backReady,
  input logic [LANES-1:0]            outValid,
  input logic [LANES-1:0]            outIsMem,
  input logic [LANES-1:0][OP_W-1:0]  outOpcode,
  input logic [LANES-1:0][REG_W-1:0] outDst,
  input logic [LANES-1:0][REG_W-1:0] outSrc,
  input logic [CNT_W-1:0]            occupancy
);
  logic accepting;
  assign accepting = inReady && (|inValid) && !flush;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CNT_W'(DEPTH)); // R6

  AST_STALL_WHEN_TIGHT: assert property (@(posedge clk) disable iff (!rstN)
    (occupancy > CNT_W'(DEPTH - MAX_UOPS)) |-> !inReady); // R6

  AST_THERMO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    outValid inside {3'b000, 3'b001, 3'b011, 3'b111}); // R4

  AST_HOLD_ON_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rstN)
    (!backReady && !flush && !accepting) |=> $stable(outValid) &&
      (outValid == '0 || ($stable(outIsMem) && $stable(outOpcode) &&
                          $stable(outDst) && $stable(outSrc)))); // R7

  AST_NO_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    (!backReady && !flush) |=> occupancy >= $past(occupancy)); // R7

  AST_DRAIN_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (backReady && !flush && !accepting) |=>
      occupancy == CNT_W'($past(occupancy) - CNT_W'($countones($past(outValid))))); // R5

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (occupancy == '0 && outValid == '0 && inReady)); // R8
endmodule

bind uop_crack_dispatch crack_checker #(.DEPTH(DEPTH)) u_check (
  .clk      (clk),
  .rstN     (rstN),
  .flush    (flush),
  .inValid  (inValid),
  .inReady  (inReady),
  .backReady(backReady),
  .outValid (outValid),
  .outIsMem (outIsMem),
  .outOpcode(outOpcode),
  .outDst   (outDst),
  .outSrc   (outSrc),
  .occupancy(occupancy)
);

// File: tb/sim_uop_crack_dispatch.sv
`timescale 1ns/1ps
module sim_uop_crack_dispatch;
  import crack_pkg::*;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                        rstN = 1'b0;
  logic                        flush = 1'b0;
  logic [LANES-1:0]            inValid = '0;
  logic [LANES-1:0]            inMemForm = '0;
  logic [LANES-1:0][OP_W-1:0]  inOpcode = '0;
  logic [LANES-1:0][REG_W-1:0] inDst = '0;
  logic [LANES-1:0][REG_W-1:0] inSrc = '0;
  logic                        inReady;
  logic                        backReady = 1'b0;
  logic [LANES-1:0]            outValid;
  logic [LANES-1:0]            outIsMem;
  logic [LANES-1:0][OP_W-1:0]  outOpcode;
  logic [LANES-1:0][REG_W-1:0] outDst;
  logic [LANES-1:0][REG_W-1:0] outSrc;

  uop_crack_dispatch #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .flush(flush),
    .inValid(inValid), .inMemForm(inMemForm), .inOpcode(inOpcode),
    .inDst(inDst), .inSrc(inSrc), .inReady(inReady), .backReady(backReady),
    .outValid(outValid), .outIsMem(outIsMem), .outOpcode(outOpcode),
    .outDst(outDst), .outSrc(outSrc)
  );

  int   checks = 0;
  int   errors = 0;
  uop_t model[$];

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic setGroup(logic [2:0] v, logic [2:0] m, int base);
    inValid   = v;
    inMemForm = m;
    for (int l = 0; l < LANES; l++) begin
      inOpcode[l] = OP_W'(base + l);
      inDst[l]    = REG_W'(base + 2 * l + 1);
      inSrc[l]    = REG_W'(base + 3 * l + 2);
    end
  endtask

  task automatic idle();
    inValid = '0;
    inMemForm = '0;
  endtask

  // One cycle: compare at the falling edge, then update the model at the rising edge.
  task automatic step(string tag);
    int   n;
    bit   expReady;
    uop_t u;
    @(negedge clk);
    n = (model.size() > LANES) ? LANES : model.size();
    expReady = (DEPTH - model.size()) >= MAX_UOPS;
    check(tag, "inReady", int'(inReady), int'(expReady));
    check(tag, "outValid", int'(outValid), (1 << n) - 1);
    for (int j = 0; j < n; j++) begin
      check(tag, $sformatf("lane%0d uop", j),
            int'({outIsMem[j], outOpcode[j], outDst[j], outSrc[j]}), int'(model[j]));
    end
    @(posedge clk);
    if (flush) begin
      model.delete();
    end else begin
      if (backReady) repeat (n) void'(model.pop_front());
      if (expReady) begin
        for (int l = 0; l < LANES; l++) begin
          if (inValid[l]) begin
            u.isMem  = 1'b0;
            u.opcode = inOpcode[l];
            u.dst    = inDst[l];
            u.src    = inSrc[l];
            if (inMemForm[l]) begin
              u.isMem = 1'b1;
              model.push_back(u);
              u.isMem = 1'b0;
            end
            model.push_back(u);
          end
        end
      end
    end
    #1;
  endtask

  task automatic drain(string tag);
    backReady = 1'b1;
    idle();
    for (int i = 0; i < 6 && model.size() != 0; i++) step(tag);
    step(tag);
  endtask

  task automatic t_reset();
    step("R9");
  endtask

  task automatic t_regreg();
    backReady = 1'b1;
    setGroup(3'b111, 3'b000, 8);
    step("R2");
    idle();
    step("R2");
    step("R5");
  endtask

  task automatic t_regmem();
    backReady = 1'b1;
    setGroup(3'b111, 3'b111, 16);
    step("R3");
    idle();
    step("R3");
    step("R5");
    step("R5");
  endtask

  task automatic t_sparse();
    backReady = 1'b1;
    setGroup(3'b101, 3'b001, 24);
    step("R1");
    setGroup(3'b110, 3'b100, 32);
    step("R1");
    setGroup(3'b010, 3'b010, 40);
    step("R4");
    drain("R4");
  endtask

  task automatic t_backpressure();
    backReady = 1'b0;
    setGroup(3'b111, 3'b111, 48);
    step("R6");
    setGroup(3'b111, 3'b000, 56);
    step("R6");
    step("R7");
    idle();
    step("R7");
    drain("R7");
  endtask

  task automatic t_flush();
    backReady = 1'b0;
    setGroup(3'b011, 3'b010, 4);
    step("R8");
    flush = 1'b1;
    setGroup(3'b111, 3'b101, 12);
    step("R8");
    flush = 1'b0;
    idle();
    step("R8");
    step("R8");
  endtask

  task automatic t_stream();
    backReady = 1'b1;
    for (int i = 0; i < 10; i++) begin
      setGroup(3'(i + 1), 3'(i * 5), 20 + 3 * i);
      backReady = (i % 3) != 2;
      step("R5");
    end
    drain("R4");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    t_reset();
    t_regreg();
    t_regmem();
    t_sparse();
    t_backpressure();
    t_flush();
    t_stream();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  end
endmodule